// File: doc/BRIEF.md
# Secured Sector Lock Controller

This block sits in front of a main memory array and guards a small secured region beside it. A write port takes command cycles. A read port takes read requests. While the block is outside the region, reads and programs pass through to the main array. A fixed three-cycle unlock-and-enter sequence switches both ports to the secured region. An exit sequence, or a single reset command, switches them back.

The secured region is a small register array. Programming follows flash rules: a write can only clear bits. The first eight bytes hold a 64-bit password. Two one-way lock bits gate later operations, and each reaches a different set of bytes:
- The password lock makes bytes 0 to 7 unreachable for both reads and programs.
- The protection bit freezes the whole region against programming.

Neither lock bit can be cleared by a command, and the ordinary reset leaves them alone. Only the test-only initialisation input clears them, and it also refills the region with ones.

Both data ports follow valid/ready rules. `wr_ready` and `rd_ready` are held high, so each cycle with valid high is one accepted transfer, and the block never stalls a source. The read response cannot be back-pressured: `rd_rsp_valid` is high for exactly one cycle, one clock after the accepted request, and the consumer must take the data in that cycle.

Top module: `vault_sector_ctrl`

## Requirements
- R1: After `rst_n` is released, `in_region`, `op_denied`, `rd_rsp_valid` and `main_prog_valid` are 0, and `wr_ready` and `rd_ready` are 1. `op_denied` is only ever high in the cycle after an accepted read or write.
- R2: The block enters the region in the cycle after three accepted writes, in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x88). A write that breaks this pattern returns the decoder to idle without entering.
- R3: Inside the region, leaving happens in the cycle after either of two things:
  - the two unlock writes, then (0x555, 0x90), then a write with data 0x00;
  - a write with data 0xF0 while the decoder is not waiting for program data or exit data.
- R4: Inside the region, the two unlock writes, then (0x555, 0xA0), then (offset, d) store `old & d` at that offset. Bits only go from 1 to 0.
- R5: Inside the region, an accepted read of an offset returns the stored byte one cycle later with `rd_rsp_valid` high.
- R6: After the unlock writes and (0x555, 0x60) inside the region, the password lock is set. From then on, a read or program of offsets 0 to 7 is refused: the read returns 0xFF, and `op_denied` is high for one clock. Offsets 8 and above are not affected. Outside the region, this sequence sets no lock.
- R7: After the unlock writes and (0x555, 0x68) inside the region, the protection bit is set. From then on, every program inside the region is refused, with `op_denied` high and the storage unchanged. Reads are still served.
- R8: No command clears either lock bit, and `rst_n` does not clear them. `init_i` clears both lock bits and fills every region byte with 0xFF.
- R9: The two lock bits may be set in either order. Region bytes may be programmed before or after the password bytes, and before or after the password lock is set.
- R10: Outside the region, a read drives `main_rd_en` and `main_rd_addr` in the same cycle and returns `main_rd_data` one cycle later. A completed program sequence raises `main_prog_valid` for one clock, carrying its address and data. The region is never touched.
- R11: Inside the region, a read or program at an offset at or above the region size is refused: the read returns 0xFF, and `op_denied` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (decoder and port state only) |
| init_i | input | 1 | Test-only initialisation: clears lock bits, fills region with ones |
| wr_valid | input | 1 | Command/data write valid |
| wr_ready | output | 1 | Write ready, held high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read ready, held high |
| rd_addr | input | ADDR_W | Read address |
| rd_rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rd_rsp_data | output | DATA_W | Read response data |
| main_rd_en | output | 1 | Read strobe to the main array |
| main_rd_addr | output | ADDR_W | Read address to the main array |
| main_rd_data | input | DATA_W | Same-cycle read data from the main array |
| main_prog_valid | output | 1 | Program strobe to the main array |
| main_prog_addr | output | ADDR_W | Program address to the main array |
| main_prog_data | output | DATA_W | Program data to the main array |
| in_region | output | 1 | Accesses currently go to the secured region |
| op_denied | output | 1 | One-clock pulse for a refused operation |

## Verification
The assertions take for granted that `init_i` is pulsed at least once before the lock bits are relied on, because they have no reset value of their own. They also take for granted that `init_i` is never raised while a locked state is being checked for stickiness, since it is the one legal way to clear a lock. The bench keeps to this: it raises `init_i` only while `rst_n` is low, or in quiet cycles between scenarios, and it never mixes it with an unlock sequence. Every write and read is a single accepted transfer on a clock edge, which matches the always-ready rule of the ports.

// File: rtl/vault_pkg.sv
`timescale 1ns/1ps
package vault_pkg;

  // Command decoder states
  typedef enum logic [2:0] {
    DS_IDLE,
    DS_KEY1,
    DS_KEY2,
    DS_PROG,
    DS_EXIT
  } dec_state_e;

  // Lock bit positions
  localparam int LK_PW    = 0;
  localparam int LK_PROT  = 1;
  localparam int LK_COUNT = 2;

  // Command addresses
  localparam logic [11:0] ADR_KEY1 = 12'h555;
  localparam logic [11:0] ADR_KEY2 = 12'h2AA;

  // Command data codes
  localparam logic [7:0] OP_KEY1      = 8'hAA;
  localparam logic [7:0] OP_KEY2      = 8'h55;
  localparam logic [7:0] OP_ENTER     = 8'h88;
  localparam logic [7:0] OP_PROG      = 8'hA0;
  localparam logic [7:0] OP_PWLOCK    = 8'h60;
  localparam logic [7:0] OP_PROTECT   = 8'h68;
  localparam logic [7:0] OP_EXIT      = 8'h90;
  localparam logic [7:0] OP_EXIT_CONF = 8'h00;
  localparam logic [7:0] OP_RESET     = 8'hF0;

endpackage

// File: rtl/vault_cmd_decode.sv
`timescale 1ns/1ps
module vault_cmd_decode
  import vault_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_region,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enter_p,
  output logic              exit_p,
  output logic              set_pw_p,
  output logic              set_prot_p,
  output logic              prog_p
);

  localparam logic [ADDR_W-1:0] A_K1 = ADDR_W'(ADR_KEY1);
  localparam logic [ADDR_W-1:0] A_K2 = ADDR_W'(ADR_KEY2);
  localparam logic [DATA_W-1:0] C_K1 = DATA_W'(OP_KEY1);
  localparam logic [DATA_W-1:0] C_K2 = DATA_W'(OP_KEY2);
  localparam logic [DATA_W-1:0] C_EN = DATA_W'(OP_ENTER);
  localparam logic [DATA_W-1:0] C_PG = DATA_W'(OP_PROG);
  localparam logic [DATA_W-1:0] C_PW = DATA_W'(OP_PWLOCK);
  localparam logic [DATA_W-1:0] C_PR = DATA_W'(OP_PROTECT);
  localparam logic [DATA_W-1:0] C_EX = DATA_W'(OP_EXIT);
  localparam logic [DATA_W-1:0] C_EC = DATA_W'(OP_EXIT_CONF);
  localparam logic [DATA_W-1:0] C_RS = DATA_W'(OP_RESET);

  dec_state_e st_q, st_d;
  logic       is_reset_op;

  assign is_reset_op = (wr_data == C_RS);

  always_comb begin
    st_d       = st_q;
    enter_p    = 1'b0;
    exit_p     = 1'b0;
    set_pw_p   = 1'b0;
    set_prot_p = 1'b0;
    prog_p     = 1'b0;
    if (wr_valid) begin
      case (st_q)
        DS_IDLE: begin
          if (is_reset_op) exit_p = 1'b1;
          else if (wr_addr == A_K1 && wr_data == C_K1) st_d = DS_KEY1;
        end
        DS_KEY1: begin
          st_d = DS_IDLE;
          if (is_reset_op) exit_p = 1'b1;
          else if (wr_addr == A_K2 && wr_data == C_K2) st_d = DS_KEY2;
        end
        DS_KEY2: begin
          st_d = DS_IDLE;
          if (is_reset_op) exit_p = 1'b1;
          else if (wr_addr == A_K1) begin
            if (wr_data == C_EN && !in_region) enter_p = 1'b1;
            else if (wr_data == C_PG) st_d = DS_PROG;
            else if (in_region) begin
              if (wr_data == C_PW) set_pw_p = 1'b1;
              else if (wr_data == C_PR) set_prot_p = 1'b1;
              else if (wr_data == C_EX) st_d = DS_EXIT;
            end
          end
        end
        DS_PROG: begin
          prog_p = 1'b1;
          st_d   = DS_IDLE;
        end
        DS_EXIT: begin
          st_d = DS_IDLE;
          if (wr_data == C_EC) exit_p = 1'b1;
        end
        default: st_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DS_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/vault_lock_bits.sv
`timescale 1ns/1ps
module vault_lock_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         init_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] lock_q
);

  // No reset input: the bits model non-volatile cells.
  always_ff @(posedge clk) begin
    if (init_i) lock_q <= '0;
    else        lock_q <= lock_q | set_i;
  end

endmodule

// File: rtl/vault_region_store.sv
`timescale 1ns/1ps
module vault_region_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              init_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic [DEPTH-1:0]  hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = we_i && (widx_i == IDX_W'(g));
  end

  // Flash-style programming: bits only fall.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (init_i)      cell_q[i] <= '1;
      else if (hit[i]) cell_q[i] <= cell_q[i] & wdata_i;
    end
  end

  assign rdata_o = cell_q[ridx_i];

endmodule

// File: rtl/vault_sector_ctrl.sv
`timescale 1ns/1ps
module vault_sector_ctrl
  import vault_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int REGION_BYTES = 32,
  parameter int PW_BYTES     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rsp_valid,
  output logic [DATA_W-1:0] rd_rsp_data,
  output logic              main_rd_en,
  output logic [ADDR_W-1:0] main_rd_addr,
  input  logic [DATA_W-1:0] main_rd_data,
  output logic              main_prog_valid,
  output logic [ADDR_W-1:0] main_prog_addr,
  output logic [DATA_W-1:0] main_prog_data,
  output logic              in_region,
  output logic              op_denied
);

  localparam int                IDX_W    = $clog2(REGION_BYTES);
  localparam logic [ADDR_W-1:0] SPAN_LIM = ADDR_W'(REGION_BYTES);
  localparam logic [ADDR_W-1:0] PW_LIM   = ADDR_W'(PW_BYTES);

  logic enter_p, exit_p, set_pw_p, set_prot_p, prog_p;
  logic [LK_COUNT-1:0] lock_q, lock_set;
  logic in_region_q;
  logic wr_in_span, wr_in_pw, rd_in_span, rd_in_pw;
  logic prog_deny, store_we, rd_deny;
  logic [DATA_W-1:0] store_rdata;
  logic rsp_valid_q, denied_q, mprog_valid_q;
  logic [DATA_W-1:0] rsp_data_q, mprog_data_q;
  logic [ADDR_W-1:0] mprog_addr_q;

  vault_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_region  (in_region_q),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .enter_p    (enter_p),
    .exit_p     (exit_p),
    .set_pw_p   (set_pw_p),
    .set_prot_p (set_prot_p),
    .prog_p     (prog_p)
  );

  always_comb begin
    lock_set          = '0;
    lock_set[LK_PW]   = set_pw_p;
    lock_set[LK_PROT] = set_prot_p;
  end

  vault_lock_bits #(.N(LK_COUNT)) u_lock (
    .clk    (clk),
    .init_i (init_i),
    .set_i  (lock_set),
    .lock_q (lock_q)
  );

  // Gating of region accesses
  assign wr_in_span = wr_addr < SPAN_LIM;
  assign wr_in_pw   = wr_addr < PW_LIM;
  assign rd_in_span = rd_addr < SPAN_LIM;
  assign rd_in_pw   = rd_addr < PW_LIM;

  assign prog_deny = prog_p && in_region_q &&
                     (!wr_in_span || lock_q[LK_PROT] || (lock_q[LK_PW] && wr_in_pw));
  assign store_we  = prog_p && in_region_q && !prog_deny;
  assign rd_deny   = rd_valid && in_region_q &&
                     (!rd_in_span || (lock_q[LK_PW] && rd_in_pw));

  vault_region_store #(.DEPTH(REGION_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .init_i  (init_i),
    .we_i    (store_we),
    .widx_i  (wr_addr[IDX_W-1:0]),
    .wdata_i (wr_data),
    .ridx_i  (rd_addr[IDX_W-1:0]),
    .rdata_o (store_rdata)
  );

  // Region selection and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_region_q   <= 1'b0;
      rsp_valid_q   <= 1'b0;
      rsp_data_q    <= '0;
      denied_q      <= 1'b0;
      mprog_valid_q <= 1'b0;
      mprog_addr_q  <= '0;
      mprog_data_q  <= '0;
    end else begin
      if (exit_p)       in_region_q <= 1'b0;
      else if (enter_p) in_region_q <= 1'b1;
      rsp_valid_q <= rd_valid;
      if (rd_valid) begin
        if (!in_region_q) rsp_data_q <= main_rd_data;
        else if (rd_deny) rsp_data_q <= '1;
        else              rsp_data_q <= store_rdata;
      end
      denied_q      <= rd_deny || prog_deny;
      mprog_valid_q <= prog_p && !in_region_q;
      if (prog_p && !in_region_q) begin
        mprog_addr_q <= wr_addr;
        mprog_data_q <= wr_data;
      end
    end
  end

  assign wr_ready        = 1'b1;
  assign rd_ready        = 1'b1;
  assign main_rd_en      = rd_valid && !in_region_q;
  assign main_rd_addr    = rd_addr;
  assign rd_rsp_valid    = rsp_valid_q;
  assign rd_rsp_data     = rsp_data_q;
  assign main_prog_valid = mprog_valid_q;
  assign main_prog_addr  = mprog_addr_q;
  assign main_prog_data  = mprog_data_q;
  assign in_region       = in_region_q;
  assign op_denied       = denied_q;

endmodule

// File: rtl/vault_sector_chk.sv
`timescale 1ns/1ps
module vault_sector_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int PW_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rsp_valid,
  input logic [DATA_W-1:0] rd_rsp_data,
  input logic              main_rd_en,
  input logic              in_region,
  input logic              op_denied,
  input logic [1:0]        lock_q,
  input logic              store_we
);

  // R1
  denied_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_denied |-> $past(rd_valid || wr_valid));

  // R2
  entry_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_region) |-> $past(wr_valid && wr_data == DATA_W'(8'h88)));

  // R6
  pw_read_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && in_region && lock_q[0] && rd_addr < ADDR_W'(PW_BYTES))
    |=> (rd_rsp_valid && rd_rsp_data == '1 && op_denied));

  // R7
  protect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[1] |-> !store_we);

  // R8
  pw_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[0] && !init_i) |=> lock_q[0]);

  // R8
  prot_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[1] && !init_i) |=> lock_q[1]);

  // R10
  main_read_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_rd_en |-> (rd_valid && !in_region));

endmodule

bind vault_sector_ctrl vault_sector_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PW_BYTES (PW_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_i       (init_i),
  .wr_valid     (wr_valid),
  .wr_data      (wr_data),
  .rd_valid     (rd_valid),
  .rd_addr      (rd_addr),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_data  (rd_rsp_data),
  .main_rd_en   (main_rd_en),
  .in_region    (in_region),
  .op_denied    (op_denied),
  .lock_q       (lock_q),
  .store_we     (store_we)
);

// File: tb/sim_vault_sector_ctrl.sv
`timescale 1ns/1ps
module sim_vault_sector_ctrl;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int RB = 32;
  localparam int PB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_ready, rd_rsp_valid, main_rd_en, main_prog_valid, in_region, op_denied;
  logic [DW-1:0] rd_rsp_data, main_rd_data, main_prog_data;
  logic [AW-1:0] main_rd_addr, main_prog_addr;

  always #10 clk = ~clk;  // 50 MHz

  // Main array stand-in: data is a fixed function of the address
  assign main_rd_data = main_rd_addr[7:0] ^ 8'h5A;

  vault_sector_ctrl #(.ADDR_W(AW), .DATA_W(DW), .REGION_BYTES(RB), .PW_BYTES(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .init_i(init_i),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .main_rd_en(main_rd_en), .main_rd_addr(main_rd_addr), .main_rd_data(main_rd_data),
    .main_prog_valid(main_prog_valid), .main_prog_addr(main_prog_addr),
    .main_prog_data(main_prog_data), .in_region(in_region), .op_denied(op_denied)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_stage;   // 0 idle, 1 key1 seen, 2 key2 seen, 3 want program data, 4 want exit confirm
  bit          m_in, m_pw, m_prot;
  byte unsigned m_mem [RB];
  bit          m_rv, m_den, m_mpv;
  logic [7:0]  m_rd, m_mpd;
  logic [AW-1:0] m_mpa;

  always @(posedge clk) begin
    automatic bit rd_ref = 0, wr_ref = 0, do_enter = 0, do_exit = 0, do_prog = 0;
    automatic bit do_pw = 0, do_prot = 0;
    automatic int nstage = m_stage;
    automatic int ra = int'(rd_addr);
    automatic int wa = int'(wr_addr);
    if (wr_valid) begin
      nstage = 0;
      if (m_stage == 3) do_prog = 1;
      else if (m_stage == 4) do_exit = (wr_data == 8'h00);
      else if (wr_data == 8'hF0) do_exit = 1;
      else if (m_stage == 0) nstage = (wa == 'h555 && wr_data == 8'hAA) ? 1 : 0;
      else if (m_stage == 1) nstage = (wa == 'h2AA && wr_data == 8'h55) ? 2 : 0;
      else if (wa == 'h555) begin
        if (wr_data == 8'h88 && !m_in) do_enter = 1;
        else if (wr_data == 8'hA0) nstage = 3;
        else if (m_in && wr_data == 8'h60) do_pw = 1;
        else if (m_in && wr_data == 8'h68) do_prot = 1;
        else if (m_in && wr_data == 8'h90) nstage = 4;
      end
    end
    if (rd_valid && m_in) rd_ref = (ra >= RB) || (m_pw && ra < PB);
    if (do_prog && m_in)  wr_ref = (wa >= RB) || m_prot || (m_pw && wa < PB);
    if (!rst_n) begin
      m_stage = 0; m_in = 0; m_rv = 0; m_den = 0; m_mpv = 0; m_rd = '0;
    end else begin
      m_rv = rd_valid;
      if (rd_valid) m_rd = !m_in ? (rd_addr[7:0] ^ 8'h5A) : (rd_ref ? 8'hFF : m_mem[ra % RB]);
      m_den = rd_ref || wr_ref;
      m_mpv = do_prog && !m_in;
      if (m_mpv) begin m_mpa = wr_addr; m_mpd = wr_data; end
    end
    if (init_i) begin
      m_pw = 0; m_prot = 0;
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
    end else begin
      if (do_pw) m_pw = 1;
      if (do_prot) m_prot = 1;
      if (do_prog && m_in && !wr_ref) m_mem[wa] = m_mem[wa] & wr_data;
    end
    if (rst_n) begin
      m_stage = nstage;
      if (do_exit) m_in = 0;
      else if (do_enter) m_in = 1;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 wr_ready", wr_ready, 1);
      chk("R1 rd_ready", rd_ready, 1);
      chk("R2/R3 in_region", in_region, m_in);
      chk("R6/R7/R11 op_denied", op_denied, m_den);
      chk("R5 rd_rsp_valid", rd_rsp_valid, m_rv);
      if (m_rv) chk("R5/R10 rd_rsp_data", rd_rsp_data, m_rd);
      chk("R10 main_rd_en", main_rd_en, rd_valid && !m_in);
      chk("R10 main_prog_valid", main_prog_valid, m_mpv);
      if (m_mpv) begin
        chk("R10 main_prog_addr", main_prog_addr, m_mpa);
        chk("R10 main_prog_data", main_prog_data, m_mpd);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA);
    wr(12'h2AA, 8'h55);
  endtask

  task automatic cmd(input logic [7:0] op);
    unlock();
    wr(12'h555, op);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    cmd(8'hA0);
    wr(a, d);
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [7:0] exp,
                             input bit exp_den, input string tag);
    @(posedge clk); #2;
    rd_valid = 1'b1; rd_addr = a;
    @(posedge clk); #2;
    rd_valid = 1'b0;
    @(negedge clk);
    chk({tag, " read data"}, rd_rsp_data, exp);
    chk({tag, " op_denied"}, op_denied, exp_den);
  endtask

  task automatic expect_in(input bit exp, input string tag);
    @(negedge clk);
    chk({tag, " in_region"}, in_region, exp);
  endtask

  task automatic do_init();
    @(posedge clk); #2; init_i = 1'b1;
    @(posedge clk); #2; init_i = 1'b0;
  endtask

  task automatic pulse_reset();
    @(posedge clk); #2; rst_n = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1;
  endtask

  // ---------------- directed scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2; init_i = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 in_region", in_region, 0);
    chk("R1 op_denied", op_denied, 0);
    chk("R1 rd_rsp_valid", rd_rsp_valid, 0);
    chk("R1 main_prog_valid", main_prog_valid, 0);

    // R10: main array routing before entry
    expect_read(12'h010, 8'h4A, 0, "R10 main");
    prog(12'h123, 8'h3C);

    // R2: broken sequences do not enter
    cmd(8'h77);
    expect_in(0, "R2 wrong op");
    wr(12'h555, 8'hAA); wr(12'h123, 8'h55); wr(12'h555, 8'h88);
    expect_in(0, "R2 wrong addr");
    cmd(8'h88);
    expect_in(1, "R2 enter");

    // R4/R5: AND programming
    prog(12'd9, 8'hF0);
    prog(12'd9, 8'h3C);
    expect_read(12'd9, 8'h30, 0, "R4 and");
    prog(12'd2, 8'hA5);
    expect_read(12'd2, 8'hA5, 0, "R9 pw before lock");
    expect_read(12'd12, 8'hFF, 0, "R5 blank");

    // R11: out of span
    expect_read(12'd40, 8'hFF, 1, "R11 read");
    prog(12'd40, 8'h00);

    // R6: password lock
    cmd(8'h60);
    expect_read(12'd2, 8'hFF, 1, "R6 pw read");
    prog(12'd3, 8'h00);
    expect_read(12'd9, 8'h30, 0, "R6 other byte");
    prog(12'd20, 8'h0F);
    expect_read(12'd20, 8'h0F, 0, "R9 program after pw lock");

    // R3: exit by sequence
    cmd(8'h90);
    wr(12'h000, 8'h00);
    expect_in(0, "R3 exit seq");

    // R8: lock survives reset
    pulse_reset();
    cmd(8'h88);
    expect_in(1, "R8 reenter");
    expect_read(12'd2, 8'hFF, 1, "R8 lock after reset");

    // R7: protection bit
    cmd(8'h68);
    prog(12'd20, 8'h00);
    expect_read(12'd20, 8'h0F, 0, "R7 unchanged");
    expect_read(12'd9, 8'h30, 0, "R7 read allowed");

    // R3: single reset command
    wr(12'h000, 8'hF0);
    expect_in(0, "R3 reset cmd");

    // R8: init clears everything
    do_init();
    cmd(8'h60);  // outside the region: no effect (R6)
    cmd(8'h88);
    expect_read(12'd2, 8'hFF, 0, "R6 lock cmd outside region");
    expect_read(12'd20, 8'hFF, 0, "R8 init refill");

    // R9: protection first, then password lock
    cmd(8'h68);
    prog(12'd2, 8'h00);
    expect_read(12'd2, 8'hFF, 0, "R9 prot first");
    cmd(8'h60);
    expect_read(12'd2, 8'hFF, 1, "R9 pw second");
    expect_read(12'd8, 8'hFF, 0, "R9 byte 8 open");

    wr(12'h000, 8'hF0);
    expect_read(12'h020, 8'h7A, 0, "R10 main after exit");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule